// File: doc/BRIEF.md
# Energy-Indexed Loss Threshold Comparator with Channel Masking

This block sits after the running-sum engine of a loss-monitoring card. Each running sum arrives tagged with its detector channel and integration-window index. A local threshold table is indexed by channel, window and the quantised beam-energy level presented with the sum. Every fresh sum is compared against its threshold. A sum above its limit raises a dump request for its channel. A request reaches the beam-permit output only after a per-channel qualification: unconnected channels are ignored, critical channels always count, and maskable channels count unless the operator inhibit is set. Once the permit drops, it stays down until an explicit rearm.

For logging, the block keeps the largest sum seen per channel and window since the last one-second tick. On each tick it copies these values into a snapshot bank and restarts the interval. Any snapshot entry can be read out together with its threshold at the present energy level.

Top module: `thrcmp_top`

## Requirements
- R1: While reset is held and right after it, beamPermit is 1, cmpValid is 0, cmpOver is 0 and dumpReq is all zeros.
- R2: The threshold written through the load port for channel c, window w and energy level l is the limit applied to a sum tagged (c, w) that arrives with energyLvl = l.
- R3: A sum is over its limit only when it is strictly greater than the threshold; an equal sum is not over. cmpValid, cmpOver, cmpChan and cmpWin for a sum presented in cycle n appear in cycle n+2, and a new sum can be accepted every cycle.
- R4: The energy level is sampled in the same cycle as the sum. A change of energyLvl in a later cycle does not alter a compare already accepted.
- R5: The class of channel k is chanClass[2k+1:2k]: 2'b00 means unconnected and never produces a dump request; 2'b01 means maskable; 2'b10 and 2'b11 mean critical.
- R6: When inhibit is 1 in the cycle a sum is accepted, an over-limit sum from a maskable channel produces no dump request and leaves beamPermit unchanged. An over-limit sum from a critical channel still produces one.
- R7: A qualified over-limit compare sets exactly bit cmpChan of dumpReq, in the same cycle as its cmpValid. In every other cycle dumpReq is zero.
- R8: beamPermit goes to 0 in the cycle a dump request appears. It then stays 0 through later compares that are under the limit, and returns to 1 one cycle after a rearm pulse. If a rearm pulse coincides with a qualified dump, the permit stays 0.
- R9: A secTick pulse copies the interval maximum of every (channel, window) into the snapshot bank and restarts each interval at 0. logMax and logThr show the snapshot and the threshold for (logChan, logWin, energyLvl) one cycle after these are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sumValid | input | 1 | A new running sum is present this cycle |
| sumChan | input | 4 | Channel of the sum |
| sumWin | input | 4 | Integration-window index of the sum |
| sumValue | input | 24 | Running-sum value, unsigned |
| energyLvl | input | 5 | Quantised beam-energy level |
| chanClass | input | 32 | Two class bits per channel |
| inhibit | input | 1 | Operator inhibit for maskable channels |
| rearm | input | 1 | Restores the beam permit |
| secTick | input | 1 | One-second logging strobe |
| thrWrEn | input | 1 | Threshold table write enable |
| thrWrChan | input | 4 | Channel of the threshold write |
| thrWrWin | input | 4 | Window of the threshold write |
| thrWrLvl | input | 5 | Energy level of the threshold write |
| thrWrData | input | 24 | Threshold value |
| logChan | input | 4 | Channel selected for log readout |
| logWin | input | 4 | Window selected for log readout |
| cmpValid | output | 1 | Compare result valid |
| cmpChan | output | 4 | Channel of the result |
| cmpWin | output | 4 | Window of the result |
| cmpOver | output | 1 | Sum exceeded its threshold (before qualification) |
| dumpReq | output | 16 | Qualified dump request, one bit per channel |
| beamPermit | output | 1 | Beam permit, active high, latched low |
| logMax | output | 24 | Snapshot maximum for the selected entry |
| logThr | output | 24 | Threshold for the selected entry at the current level |

## Verification
The properties assume that rearm is the only way the permit can come back. They also assume that sumChan, sumWin and energyLvl stay inside the table dimensions, so every compare reads a location that was written. The stimulus loads all 6144 thresholds first and never writes the table while it reads the same entry. It uses only in-range tags, and it keeps secTick apart from compares that are still in flight, so each sum falls clearly within one logging interval.

// File: rtl/thrcmp_pkg.sv
package thrcmp_pkg;
  typedef enum logic [1:0] {
    CLS_OPEN  = 2'b00,
    CLS_MASK  = 2'b01,
    CLS_CRIT  = 2'b10,
    CLS_CRITX = 2'b11
  } chanClass_t;

  typedef struct packed {
    logic capture;
    logic evaluate;
    logic snapshot;
  } strobe_t;
endpackage

// File: rtl/thrcmp_ctrl.sv
module thrcmp_ctrl
  import thrcmp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sumValid,
  input  logic    secTick,
  input  logic    rearm,
  input  logic    tripHit,
  output strobe_t strb,
  output logic    cmpValid,
  output logic    beamPermit
);
  logic s1Valid;

  always_comb begin
    strb.capture  = sumValid;
    strb.evaluate = s1Valid;
    strb.snapshot = secTick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid    <= 1'b0;
      cmpValid   <= 1'b0;
      beamPermit <= 1'b1;
    end else begin
      s1Valid  <= sumValid;
      cmpValid <= s1Valid;
      if (s1Valid && tripHit) beamPermit <= 1'b0;
      else if (rearm)         beamPermit <= 1'b1;
    end
  end
endmodule

// File: rtl/thrcmp_dp.sv
module thrcmp_dp
  import thrcmp_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int NWIN = 12,
  parameter int NLVL = 32,
  parameter int SW   = 24,
  localparam int CW  = $clog2(NCH),
  localparam int WW  = $clog2(NWIN),
  localparam int LW  = $clog2(NLVL)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [CW-1:0]     sumChan,
  input  logic [WW-1:0]     sumWin,
  input  logic [SW-1:0]     sumValue,
  input  logic [LW-1:0]     energyLvl,
  input  logic [2*NCH-1:0]  chanClass,
  input  logic              inhibit,
  input  logic              thrWrEn,
  input  logic [CW-1:0]     thrWrChan,
  input  logic [WW-1:0]     thrWrWin,
  input  logic [LW-1:0]     thrWrLvl,
  input  logic [SW-1:0]     thrWrData,
  input  logic [CW-1:0]     logChan,
  input  logic [WW-1:0]     logWin,
  output logic              tripHit,
  output logic [CW-1:0]     cmpChan,
  output logic [WW-1:0]     cmpWin,
  output logic              cmpOver,
  output logic [NCH-1:0]    dumpReq,
  output logic [SW-1:0]     logMax,
  output logic [SW-1:0]     logThr
);
  localparam int NENT  = NCH * NWIN;
  localparam int DEPTH = NENT * NLVL;
  localparam int AW    = $clog2(DEPTH);
  localparam int EW    = $clog2(NENT);

  function automatic logic [AW-1:0] thrIdx(input logic [CW-1:0] c,
                                           input logic [WW-1:0] w,
                                           input logic [LW-1:0] l);
    return AW'(c) * AW'(NWIN * NLVL) + AW'(w) * AW'(NLVL) + AW'(l);
  endfunction

  function automatic logic [EW-1:0] entIdx(input logic [CW-1:0] c,
                                           input logic [WW-1:0] w);
    return EW'(c) * EW'(NWIN) + EW'(w);
  endfunction

  logic [SW-1:0] thrMem [DEPTH];
  logic [SW-1:0] thrRd;

  always_ff @(posedge clk) begin
    if (thrWrEn) thrMem[thrIdx(thrWrChan, thrWrWin, thrWrLvl)] <= thrWrData;
    if (strb.capture) thrRd <= thrMem[thrIdx(sumChan, sumWin, energyLvl)];
    logThr <= thrMem[thrIdx(logChan, logWin, energyLvl)];
  end

  // stage 1: sum and qualifiers held alongside the table read
  logic [SW-1:0] s1Sum;
  logic [CW-1:0] s1Chan;
  logic [WW-1:0] s1Win;
  logic          s1Inh;
  chanClass_t    s1Cls;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Sum  <= '0;
      s1Chan <= '0;
      s1Win  <= '0;
      s1Inh  <= 1'b0;
      s1Cls  <= CLS_OPEN;
    end else if (strb.capture) begin
      s1Sum  <= sumValue;
      s1Chan <= sumChan;
      s1Win  <= sumWin;
      s1Inh  <= inhibit;
      s1Cls  <= chanClass_t'(chanClass[2*sumChan +: 2]);
    end
  end

  logic overNow, allowNow;
  always_comb begin
    overNow = s1Sum > thrRd;
    unique case (s1Cls)
      CLS_OPEN:  allowNow = 1'b0;
      CLS_MASK:  allowNow = !s1Inh;
      default:   allowNow = 1'b1;
    endcase
    tripHit = overNow && allowNow;
  end

  // stage 2: registered result
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpChan <= '0;
      cmpWin  <= '0;
      cmpOver <= 1'b0;
      dumpReq <= '0;
    end else begin
      cmpChan <= s1Chan;
      cmpWin  <= s1Win;
      cmpOver <= strb.evaluate && overNow;
      dumpReq <= (strb.evaluate && tripHit) ? (NCH'(1) << s1Chan) : '0;
    end
  end

  // per-entry interval maximum and snapshot
  logic [SW-1:0] snapAll [NENT];
  logic [EW-1:0] s1Ent;
  assign s1Ent = entIdx(s1Chan, s1Win);

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    logic [SW-1:0] runQ, snapQ, nextMax;
    logic          hit;
    assign hit     = strb.evaluate && (s1Ent == EW'(e));
    assign nextMax = (hit && s1Sum > runQ) ? s1Sum : runQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        runQ  <= '0;
        snapQ <= '0;
      end else if (strb.snapshot) begin
        snapQ <= nextMax;
        runQ  <= '0;
      end else begin
        runQ  <= nextMax;
      end
    end
    assign snapAll[e] = snapQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) logMax <= '0;
    else       logMax <= snapAll[entIdx(logChan, logWin)];
  end
endmodule

// File: rtl/thrcmp_top.sv
module thrcmp_top
  import thrcmp_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int NWIN = 12,
  parameter int NLVL = 32,
  parameter int SW   = 24,
  localparam int CW  = $clog2(NCH),
  localparam int WW  = $clog2(NWIN),
  localparam int LW  = $clog2(NLVL)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sumValid,
  input  logic [CW-1:0]    sumChan,
  input  logic [WW-1:0]    sumWin,
  input  logic [SW-1:0]    sumValue,
  input  logic [LW-1:0]    energyLvl,
  input  logic [2*NCH-1:0] chanClass,
  input  logic             inhibit,
  input  logic             rearm,
  input  logic             secTick,
  input  logic             thrWrEn,
  input  logic [CW-1:0]    thrWrChan,
  input  logic [WW-1:0]    thrWrWin,
  input  logic [LW-1:0]    thrWrLvl,
  input  logic [SW-1:0]    thrWrData,
  input  logic [CW-1:0]    logChan,
  input  logic [WW-1:0]    logWin,
  output logic             cmpValid,
  output logic [CW-1:0]    cmpChan,
  output logic [WW-1:0]    cmpWin,
  output logic             cmpOver,
  output logic [NCH-1:0]   dumpReq,
  output logic             beamPermit,
  output logic [SW-1:0]    logMax,
  output logic [SW-1:0]    logThr
);
  strobe_t strb;
  logic    tripHit;

  thrcmp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sumValid(sumValid), .secTick(secTick),
    .rearm(rearm), .tripHit(tripHit), .strb(strb),
    .cmpValid(cmpValid), .beamPermit(beamPermit)
  );

  thrcmp_dp #(.NCH(NCH), .NWIN(NWIN), .NLVL(NLVL), .SW(SW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .sumChan(sumChan), .sumWin(sumWin), .sumValue(sumValue),
    .energyLvl(energyLvl), .chanClass(chanClass), .inhibit(inhibit),
    .thrWrEn(thrWrEn), .thrWrChan(thrWrChan), .thrWrWin(thrWrWin),
    .thrWrLvl(thrWrLvl), .thrWrData(thrWrData),
    .logChan(logChan), .logWin(logWin),
    .tripHit(tripHit), .cmpChan(cmpChan), .cmpWin(cmpWin),
    .cmpOver(cmpOver), .dumpReq(dumpReq), .logMax(logMax), .logThr(logThr)
  );
endmodule

// File: rtl/thrcmp_chk.sv
module thrcmp_chk #(
  parameter int NCH = 16
) (
  input logic           clk,
  input logic           rstN,
  input logic           sumValid,
  input logic           rearm,
  input logic           cmpValid,
  input logic           cmpOver,
  input logic [NCH-1:0] dumpReq,
  input logic           beamPermit
);
  assert_valid_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmpValid |-> $past(sumValid, 2));

  assert_dump_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dumpReq));

  assert_dump_with_result_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|dumpReq) |-> (cmpValid && cmpOver));

  assert_dump_drops_permit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|dumpReq) |-> !beamPermit);

  assert_permit_latched_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!beamPermit && !rearm) |=> !beamPermit);

  assert_permit_rise_needs_rearm_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(beamPermit) |-> $past(rearm));
endmodule

bind thrcmp_top thrcmp_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rstN(rstN), .sumValid(sumValid), .rearm(rearm),
  .cmpValid(cmpValid), .cmpOver(cmpOver), .dumpReq(dumpReq),
  .beamPermit(beamPermit)
);

// File: tb/tb_thrcmp_top.sv
module tb_thrcmp_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sumValid = 1'b0;
  logic [3:0]  sumChan = '0;
  logic [3:0]  sumWin = '0;
  logic [23:0] sumValue = '0;
  logic [4:0]  energyLvl = '0;
  logic [31:0] chanClass;
  logic        inhibit = 1'b0;
  logic        rearm = 1'b0;
  logic        secTick = 1'b0;
  logic        thrWrEn = 1'b0;
  logic [3:0]  thrWrChan = '0;
  logic [3:0]  thrWrWin = '0;
  logic [4:0]  thrWrLvl = '0;
  logic [23:0] thrWrData = '0;
  logic [3:0]  logChan = '0;
  logic [3:0]  logWin = '0;
  logic        cmpValid, cmpOver, beamPermit;
  logic [3:0]  cmpChan, cmpWin;
  logic [15:0] dumpReq;
  logic [23:0] logMax, logThr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  thrcmp_top dut (.*);

  // channels 0-5 maskable, 6-11 critical, 12-15 unconnected (R5 encoding)
  initial begin
    for (int k = 0; k < 16; k++)
      chanClass[2*k +: 2] = (k < 6) ? 2'b01 : (k < 12) ? 2'b10 : 2'b00;
  end

  function automatic int thrFn(int c, int w, int l);
    return 1000 + c * 100 + w * 10 + l * 3;
  endfunction

  function automatic bit clsAllows(int c, bit inh);
    if (c >= 12) return 1'b0;
    if (c < 6)   return !inh;
    return 1'b1;
  endfunction

  task automatic check(string req, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doCompare(int c, int w, int l, int s);
    @(negedge clk);
    sumValid = 1'b1; sumChan = 4'(c); sumWin = 4'(w);
    energyLvl = 5'(l); sumValue = 24'(s);
    @(negedge clk);
    sumValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseRearm();
    @(negedge clk); rearm = 1'b1;
    @(negedge clk); rearm = 1'b0;
  endtask

  task automatic pulseTick();
    @(negedge clk); secTick = 1'b1;
    @(negedge clk); secTick = 1'b0;
    @(negedge clk);
  endtask

  // vector: chan, win, level, signed delta from the threshold
  localparam logic [20:0] VEC [12] = '{
    {4'd0,  4'd0,  5'd0,  8'sd1},
    {4'd0,  4'd0,  5'd0,  8'sd0},
    {4'd1,  4'd11, 5'd31, -8'sd1},
    {4'd2,  4'd5,  5'd7,  8'sd5},
    {4'd6,  4'd3,  5'd12, 8'sd1},
    {4'd7,  4'd11, 5'd31, 8'sd0},
    {4'd11, 4'd0,  5'd1,  8'sd100},
    {4'd12, 4'd4,  5'd4,  8'sd50},
    {4'd15, 4'd11, 5'd31, 8'sd1},
    {4'd5,  4'd9,  5'd20, -8'sd20},
    {4'd9,  4'd6,  5'd2,  8'sd2},
    {4'd3,  4'd1,  5'd30, 8'sd1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 permit", beamPermit, 1);
    check("R1 valid", cmpValid, 0);
    check("R1 dump", dumpReq, 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 permit after release", beamPermit, 1);
    check("R1 over after release", cmpOver, 0);

    // load the whole table
    for (int c = 0; c < 16; c++)
      for (int w = 0; w < 12; w++)
        for (int l = 0; l < 32; l++) begin
          @(negedge clk);
          thrWrEn = 1'b1; thrWrChan = 4'(c); thrWrWin = 4'(w);
          thrWrLvl = 5'(l); thrWrData = 24'(thrFn(c, w, l));
        end
    @(negedge clk); thrWrEn = 1'b0;

    // table walk: R2 lookup, R3 strict compare, R5 classes, R7 one-hot, R8 permit
    for (int i = 0; i < 12; i++) begin
      int c, w, l, d;
      bit expOver, expDump;
      c = int'(VEC[i][20:17]); w = int'(VEC[i][16:13]);
      l = int'(VEC[i][12:8]);  d = int'($signed(VEC[i][7:0]));
      expOver = d > 0;
      expDump = expOver && clsAllows(c, 1'b0);
      doCompare(c, w, l, thrFn(c, w, l) + d);
      check("R3 valid", cmpValid, 1);
      check("R3 chan", cmpChan, c);
      check("R3 win", cmpWin, w);
      check("R2 R3 over", cmpOver, expOver);
      check("R5 R7 dump", dumpReq, expDump ? (16'd1 << c) : 16'd0);
      check("R8 permit", beamPermit, !expDump);
      @(negedge clk);
      check("R7 dump clears", dumpReq, 0);
      if (expDump) begin
        pulseRearm();
        check("R8 rearm", beamPermit, 1);
      end
    end

    // R3 back-to-back and R4 energy level sampled with the sum
    @(negedge clk);
    sumValid = 1'b1; sumChan = 4'd8; sumWin = 4'd1; energyLvl = 5'd5;
    sumValue = 24'(thrFn(8, 1, 5) + 1);
    @(negedge clk);
    energyLvl = 5'd9;
    @(negedge clk);
    sumValid = 1'b0;
    check("R4 first uses old level", cmpOver, 1);
    check("R3 back-to-back valid", cmpValid, 1);
    @(negedge clk);
    check("R4 second uses new level", cmpOver, 0);
    check("R3 second valid", cmpValid, 1);
    check("R8 still low", beamPermit, 0);
    pulseRearm();
    check("R8 rearm", beamPermit, 1);

    // R6 inhibit
    inhibit = 1'b1;
    doCompare(2, 4, 10, thrFn(2, 4, 10) + 9);
    check("R6 maskable over", cmpOver, 1);
    check("R6 maskable no dump", dumpReq, 0);
    check("R6 permit kept", beamPermit, 1);
    doCompare(10, 2, 3, thrFn(10, 2, 3) + 1);
    check("R6 critical dumps", dumpReq, 16'd1 << 10);
    check("R6 permit drop", beamPermit, 0);
    inhibit = 1'b0;
    pulseRearm();

    // R8 latched through an under-limit compare, and rearm vs dump priority
    doCompare(6, 0, 0, thrFn(6, 0, 0) + 3);
    check("R8 drop", beamPermit, 0);
    doCompare(6, 0, 0, thrFn(6, 0, 0) - 3);
    check("R8 stays low", beamPermit, 0);
    pulseRearm();
    check("R8 rearm", beamPermit, 1);
    @(negedge clk);
    sumValid = 1'b1; sumChan = 4'd7; sumWin = 4'd2; energyLvl = 5'd0;
    sumValue = 24'(thrFn(7, 2, 0) + 1);
    @(negedge clk); sumValid = 1'b0; rearm = 1'b1;
    @(negedge clk); rearm = 1'b0;
    check("R8 dump beats rearm", beamPermit, 0);
    pulseRearm();
    check("R8 rearm after", beamPermit, 1);

    // R9 logging
    pulseTick();
    logChan = 4'd4; logWin = 4'd2;
    doCompare(4, 2, 7, 300);
    doCompare(4, 2, 7, 900);
    doCompare(4, 2, 7, 650);
    pulseTick();
    check("R9 max", logMax, 900);
    check("R9 thr", logThr, thrFn(4, 2, 7));
    @(negedge clk); energyLvl = 5'd3;
    @(negedge clk);
    check("R9 thr follows level", logThr, thrFn(4, 2, 3));
    pulseTick();
    check("R9 interval restart", logMax, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule